// File: doc/BRIEF.md
# FIFO Status and Interrupt Unit

This unit keeps the occupancy of a transmit queue and a receive queue for a serial controller. From that occupancy it derives a status word, threshold interrupts and sticky error interrupts, and it reports all of them to a host register interface. The host side pushes into the transmit queue and pops from the receive queue. The serial engine pops from the transmit queue and pushes into the receive queue. The unit sees only these strobes and does not hold the data.

Each interrupt source has a raw bit. A mask register selects which raw bits reach the single interrupt line, and the masked view is also available for reading. The error bits stay set until the host writes a one to the matching position of a clear register. The threshold bits have no storage: they follow the queue levels. Dropping the enable input empties both queues at once.

Top module: `fsi_top`

## Requirements
- R1: Each level counts accepted pushes minus accepted pops and stays within 0 to DEPTH. A push into a full queue or a pop from an empty queue is not accepted. When a push and a pop are both accepted in the same cycle, the level does not change. The new level appears on `tx_lvl_o` and `rx_lvl_o` one cycle after the strobe.
- R2: `status_o` has these bits: [0] follows `busy_i`, [1] TX level equals DEPTH, [2] TX level is zero, [3] RX level is zero, [4] RX level equals DEPTH, [5] follows `slv_tx_busy_i`.
- R3: A TX push while the TX level equals DEPTH sets raw bit 1 (TX overflow) in the next cycle. The level does not change. The bit stays set until it is cleared.
- R4: An RX push while the RX level equals DEPTH sets raw bit 3 (RX overflow). An RX pop while the RX level is zero sets raw bit 2 (RX underflow). Both bits are sticky.
- R5: Raw bit 0 is 1 exactly when the TX level is less than or equal to the TX threshold.
- R6: Raw bit 4 is 1 exactly when the RX level is strictly greater than the RX threshold. The clear register has no effect on it.
- R7: When `clr_we_i` is high, clear bit 0 clears all sticky bits, clear bit 1 clears RX underflow, clear bit 2 clears RX overflow and clear bit 3 clears TX overflow. If a bit is set and cleared in the same cycle, the set wins.
- R8: `irq_stat_o` is the raw word ANDed with the mask register. `irq_o` is the OR of `irq_stat_o`. The mask (`msk_we_i`, from `wdata_i[4:0]`), the TX threshold (`thr_tx_we_i`) and the RX threshold (`thr_rx_we_i`), both from `wdata_i[AW-1:0]`, load one cycle after the write strobe.
- R9: While `en_i` is low, both levels are zero from the next cycle on and all push and pop strobes are ignored. Sticky bits and configuration registers keep their values.
- R10: After reset, the levels, mask, thresholds and sticky bits are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Controller enable; low flushes both queues |
| busy_i | input | 1 | Engine busy |
| slv_tx_busy_i | input | 1 | Target-mode transmit busy |
| tx_push_i | input | 1 | Host write into the TX queue |
| tx_pop_i | input | 1 | Engine read from the TX queue |
| rx_push_i | input | 1 | Engine write into the RX queue |
| rx_pop_i | input | 1 | Host read from the RX queue |
| msk_we_i | input | 1 | Mask register write |
| thr_tx_we_i | input | 1 | TX threshold write |
| thr_rx_we_i | input | 1 | RX threshold write |
| wdata_i | input | WW | Configuration write data |
| clr_we_i | input | 1 | Clear register write |
| clr_i | input | 4 | Clear register write data |
| status_o | output | 6 | Status word |
| raw_o | output | 5 | Raw interrupt bits |
| irq_stat_o | output | 5 | Masked interrupt bits |
| mask_o | output | 5 | Mask register readback |
| irq_o | output | 1 | Interrupt line |
| tx_lvl_o | output | LW | TX occupancy |
| rx_lvl_o | output | LW | RX occupancy |

## Verification
The assertions assume that the strobes are clean single-cycle, synchronous pulses that never become X after reset. They do not assume that the producer respects the full and empty states: pushing into a full queue and popping from an empty one are legal stimulus, because these are exactly the events that create the error bits. The stimulus stays in that space. It drives every input only at the falling edge, it deliberately fills and drains each queue past both ends, it overlaps set and clear events, and it toggles the enable in the middle of traffic.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
  localparam int ST_BUSY   = 0;
  localparam int ST_TXFULL = 1;
  localparam int ST_TXEMP  = 2;
  localparam int ST_RXEMP  = 3;
  localparam int ST_RXFULL = 4;
  localparam int ST_STBUSY = 5;
  localparam int ST_W      = 6;

  localparam int IRQ_TXTHR = 0;
  localparam int IRQ_TXOVF = 1;
  localparam int IRQ_RXUDF = 2;
  localparam int IRQ_RXOVF = 3;
  localparam int IRQ_RXTHR = 4;
  localparam int IRQ_W     = 5;

  localparam int CLR_ALL   = 0;
  localparam int CLR_RXUDF = 1;
  localparam int CLR_RXOVF = 2;
  localparam int CLR_TXOVF = 3;
  localparam int CLR_W     = 4;

  // sticky vector order
  localparam int SK_TXOVF = 0;
  localparam int SK_RXUDF = 1;
  localparam int SK_RXOVF = 2;
  localparam int SK_W     = 3;
endpackage

// File: rtl/fsi_lvl_ctr.sv
module fsi_lvl_ctr #(
  parameter int DEPTH = 32,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [LW-1:0] lvl_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o,
  output logic          udf_o
);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [LW-1:0] lvl_q;
  logic          inc, dec;

  assign full_o  = (lvl_q == FULL_LVL);
  assign empty_o = (lvl_q == '0);
  assign inc     = en_i & push_i & ~full_o;
  assign dec     = en_i & pop_i & ~empty_o;
  assign ovf_o   = en_i & push_i & full_o;
  assign udf_o   = en_i & pop_i & empty_o;
  assign lvl_o   = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lvl_q <= '0;
    else if (!en_i) lvl_q <= '0;
    else            lvl_q <= lvl_q + LW'(inc) - LW'(dec);
  end

  p_lvl_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= FULL_LVL);
  p_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> lvl_q == '0);
  p_no_overfill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && push_i && full_o && !pop_i) |=> lvl_q == FULL_LVL);
  p_idle_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !push_i && !pop_i) |=> $stable(lvl_q));
endmodule

// File: rtl/fsi_sticky.sv
module fsi_sticky #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;   // set wins over clear
      else if (clr_i[i]) q <= 1'b0;
    end
    assign q_o[i] = q;

    p_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q_o[i]);
    p_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !q_o[i]);
    p_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o[i] && !clr_i[i]) |=> q_o[i]);
  end
endmodule

// File: rtl/fsi_top.sv
module fsi_top #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1),
  localparam int WW = (AW > 5) ? AW : 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          busy_i,
  input  logic          slv_tx_busy_i,
  input  logic          tx_push_i,
  input  logic          tx_pop_i,
  input  logic          rx_push_i,
  input  logic          rx_pop_i,
  input  logic          msk_we_i,
  input  logic          thr_tx_we_i,
  input  logic          thr_rx_we_i,
  input  logic [WW-1:0] wdata_i,
  input  logic          clr_we_i,
  input  logic [3:0]    clr_i,
  output logic [5:0]    status_o,
  output logic [4:0]    raw_o,
  output logic [4:0]    irq_stat_o,
  output logic [4:0]    mask_o,
  output logic          irq_o,
  output logic [LW-1:0] tx_lvl_o,
  output logic [LW-1:0] rx_lvl_o
);
  import fsi_pkg::*;

  logic [LW-1:0] tx_lvl, rx_lvl;
  logic          tx_full, tx_empty, tx_ovf, tx_udf_unused;
  logic          rx_full, rx_empty, rx_ovf, rx_udf;
  logic [AW-1:0] tx_thr_q, rx_thr_q;
  logic [IRQ_W-1:0] mask_q, raw;
  logic [SK_W-1:0]  sk_set, sk_clr, sk_q;

  fsi_lvl_ctr #(.DEPTH(DEPTH), .LW(LW)) u_tx (
    .clk_i, .rst_ni, .en_i,
    .push_i(tx_push_i), .pop_i(tx_pop_i),
    .lvl_o(tx_lvl), .full_o(tx_full), .empty_o(tx_empty),
    .ovf_o(tx_ovf), .udf_o(tx_udf_unused)
  );

  fsi_lvl_ctr #(.DEPTH(DEPTH), .LW(LW)) u_rx (
    .clk_i, .rst_ni, .en_i,
    .push_i(rx_push_i), .pop_i(rx_pop_i),
    .lvl_o(rx_lvl), .full_o(rx_full), .empty_o(rx_empty),
    .ovf_o(rx_ovf), .udf_o(rx_udf)
  );

  always_comb begin
    sk_set = '0;
    sk_set[SK_TXOVF] = tx_ovf;
    sk_set[SK_RXUDF] = rx_udf;
    sk_set[SK_RXOVF] = rx_ovf;
    sk_clr = '0;
    if (clr_we_i) begin
      sk_clr[SK_TXOVF] = clr_i[CLR_ALL] | clr_i[CLR_TXOVF];
      sk_clr[SK_RXUDF] = clr_i[CLR_ALL] | clr_i[CLR_RXUDF];
      sk_clr[SK_RXOVF] = clr_i[CLR_ALL] | clr_i[CLR_RXOVF];
    end
  end

  fsi_sticky #(.N(SK_W)) u_sticky (
    .clk_i, .rst_ni, .set_i(sk_set), .clr_i(sk_clr), .q_o(sk_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      tx_thr_q <= '0;
      rx_thr_q <= '0;
    end else begin
      if (msk_we_i)    mask_q   <= wdata_i[IRQ_W-1:0];
      if (thr_tx_we_i) tx_thr_q <= wdata_i[AW-1:0];
      if (thr_rx_we_i) rx_thr_q <= wdata_i[AW-1:0];
    end
  end

  always_comb begin
    raw            = '0;
    raw[IRQ_TXTHR] = (tx_lvl <= LW'(tx_thr_q));
    raw[IRQ_TXOVF] = sk_q[SK_TXOVF];
    raw[IRQ_RXUDF] = sk_q[SK_RXUDF];
    raw[IRQ_RXOVF] = sk_q[SK_RXOVF];
    raw[IRQ_RXTHR] = (rx_lvl > LW'(rx_thr_q));
  end

  always_comb begin
    status_o            = '0;
    status_o[ST_BUSY]   = busy_i;
    status_o[ST_TXFULL] = tx_full;
    status_o[ST_TXEMP]  = tx_empty;
    status_o[ST_RXEMP]  = rx_empty;
    status_o[ST_RXFULL] = rx_full;
    status_o[ST_STBUSY] = slv_tx_busy_i;
  end

  assign raw_o      = raw;
  assign irq_stat_o = raw & mask_q;
  assign mask_o     = mask_q;
  assign irq_o      = |irq_stat_o;
  assign tx_lvl_o   = tx_lvl;
  assign rx_lvl_o   = rx_lvl;

  p_mask_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
  p_mask_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msk_we_i |=> mask_q == $past(wdata_i[IRQ_W-1:0]));
  p_rxthr_noclr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && en_i && !rx_push_i && !rx_pop_i && !thr_rx_we_i)
      |=> raw_o[IRQ_RXTHR] == $past(raw_o[IRQ_RXTHR]));
  p_status_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[ST_TXFULL] && status_o[ST_TXEMP]));
  p_txovf_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tx_push_i && status_o[ST_TXFULL]) |=> raw_o[IRQ_TXOVF]);
endmodule

// File: tb/sim_fsi_top.sv
module sim_fsi_top;
  localparam int D = 32;
  localparam int LW = 6;
  localparam int WW = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, busy_i = 1'b0, slv_tx_busy_i = 1'b0;
  logic tx_push_i = 1'b0, tx_pop_i = 1'b0, rx_push_i = 1'b0, rx_pop_i = 1'b0;
  logic msk_we_i = 1'b0, thr_tx_we_i = 1'b0, thr_rx_we_i = 1'b0, clr_we_i = 1'b0;
  logic [WW-1:0] wdata_i = '0;
  logic [3:0] clr_i = '0;
  logic [5:0] status_o;
  logic [4:0] raw_o, irq_stat_o, mask_o;
  logic irq_o;
  logic [LW-1:0] tx_lvl_o, rx_lvl_o;

  always #10 clk_i = ~clk_i;

  fsi_top #(.DEPTH(D)) u0 (.*);

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  // reference model state
  int tl = 0, rl = 0, msk = 0, tt = 0, rt = 0;
  bit txo = 0, rxu = 0, rxo = 0;
  string tag = "R10";

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: run hung");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h @%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit tov, ro, ru;
    tov = 0; ro = 0; ru = 0;
    if (!en_i) begin tl = 0; rl = 0; end  // R9
    else begin
      int dt, dr;
      dt = 0; dr = 0;
      if (tx_push_i) begin if (tl == D) tov = 1; else dt++; end
      if (tx_pop_i && tl > 0) dt--;
      if (rx_push_i) begin if (rl == D) ro = 1; else dr++; end
      if (rx_pop_i) begin if (rl == 0) ru = 1; else dr--; end
      tl += dt; rl += dr;
    end
    if (clr_we_i) begin  // R7
      if (clr_i[0] || clr_i[3]) txo = 0;
      if (clr_i[0] || clr_i[1]) rxu = 0;
      if (clr_i[0] || clr_i[2]) rxo = 0;
    end
    if (tov) txo = 1;
    if (ru)  rxu = 1;
    if (ro)  rxo = 1;
    if (msk_we_i)    msk = int'(wdata_i);
    if (thr_tx_we_i) tt  = int'(wdata_i);
    if (thr_rx_we_i) rt  = int'(wdata_i);
  endtask

  task automatic compare();
    int st, rw;
    st = int'(busy_i) | ((tl == D) << 1) | ((tl == 0) << 2) | ((rl == 0) << 3)
       | ((rl == D) << 4) | (int'(slv_tx_busy_i) << 5);
    rw = int'(tl <= tt) | (int'(txo) << 1) | (int'(rxu) << 2) | (int'(rxo) << 3)
       | (int'(rl > rt) << 4);
    chk("R1 tx_lvl", int'(tx_lvl_o), tl);
    chk("R1 rx_lvl", int'(rx_lvl_o), rl);
    chk("R2 status", int'(status_o), st);
    chk("R5 raw_txthr", int'(raw_o[0]), rw & 1);
    chk("R3 raw_txovf", int'(raw_o[1]), (rw >> 1) & 1);
    chk("R4 raw_rx_udf_ovf", int'(raw_o[3:2]), (rw >> 2) & 3);
    chk("R6 raw_rxthr", int'(raw_o[4]), (rw >> 4) & 1);
    chk("R8 mask", int'(mask_o), msk);
    chk("R8 irq_stat", int'(irq_stat_o), rw & msk);
    chk("R8 irq", int'(irq_o), int'((rw & msk) != 0));
  endtask

  task automatic idle();
    tx_push_i = 0; tx_pop_i = 0; rx_push_i = 0; rx_pop_i = 0;
    msk_we_i = 0; thr_tx_we_i = 0; thr_rx_we_i = 0; clr_we_i = 0; clr_i = '0;
  endtask

  task automatic tick();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare();
    idle();
  endtask

  task automatic cfg(int m, int t, int r);
    msk_we_i = 1; wdata_i = WW'(m); tick();
    thr_tx_we_i = 1; wdata_i = WW'(t); tick();
    thr_rx_we_i = 1; wdata_i = WW'(r); tick();
  endtask

  initial begin
    #25 @(negedge clk_i);
    compare();  // R10 reset state
    rst_ni = 1; en_i = 1;
    tick();

    tag = "R8"; cfg(31, 4, 3);

    tag = "R3";  // fill TX past full
    for (int i = 0; i < D + 2; i++) begin tx_push_i = 1; tick(); end
    tag = "R1"; tx_push_i = 1; tx_pop_i = 1; tick();  // full: push rejected, pop taken
    for (int i = 0; i < D; i++) begin tx_pop_i = 1; busy_i = i[0]; tick(); end

    tag = "R4";  // fill RX past full, then drain past empty
    for (int i = 0; i < D + 1; i++) begin rx_push_i = 1; tick(); end
    for (int i = 0; i < D + 2; i++) begin rx_pop_i = 1; slv_tx_busy_i = i[1]; tick(); end

    tag = "R7";  // individual clears with concurrent set
    clr_we_i = 1; clr_i = 4'b1000; tick();
    rx_pop_i = 1; clr_we_i = 1; clr_i = 4'b0010; tick();  // set wins
    clr_we_i = 1; clr_i = 4'b0100; tick();
    clr_we_i = 1; clr_i = 4'b0001; tick();

    tag = "R6";  // threshold edge: level 3 -> no, 4 -> yes; clear has no effect
    for (int i = 0; i < 5; i++) begin rx_push_i = 1; tick(); end
    clr_we_i = 1; clr_i = 4'b1111; tick();
    rx_pop_i = 1; tick();
    rx_pop_i = 1; tick();

    tag = "R9";  // flush with strobes active, then still disabled
    tx_push_i = 1; tick();
    en_i = 0; tx_push_i = 1; rx_push_i = 1; tick();
    rx_pop_i = 1; tx_push_i = 1; msk_we_i = 1; wdata_i = 5'h13; tick();
    en_i = 1; tick();

    tag = "R5";
    thr_tx_we_i = 1; wdata_i = 0; tick();
    tx_push_i = 1; tick();

    tag = "RND R1 R2 R3 R4 R5 R6 R7 R8 R9";
    for (int i = 0; i < 4000; i++) begin
      int p;
      p = int'($urandom_range(0, 99));
      tx_push_i = ($urandom_range(0, 99) < 55);
      tx_pop_i  = ($urandom_range(0, 99) < 45);
      rx_push_i = ($urandom_range(0, 99) < 50);
      rx_pop_i  = ($urandom_range(0, 99) < 50);
      busy_i = $urandom_range(0, 1);
      slv_tx_busy_i = $urandom_range(0, 1);
      en_i = (p != 0);
      if (p < 6) begin clr_we_i = 1; clr_i = 4'($urandom_range(0, 15)); end
      if (p == 7) begin msk_we_i = 1; wdata_i = WW'($urandom_range(0, 31)); end
      if (p == 8) begin thr_tx_we_i = 1; wdata_i = WW'($urandom_range(0, 31)); end
      if (p == 9) begin thr_rx_we_i = 1; wdata_i = WW'($urandom_range(0, 31)); end
      tick();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule